// File: doc/BRIEF.md
# Gray-Code Group Update Sequencer

This controller drives the address, data and active-low select lines of an addressable bank of latched output channels. A caller supplies a channel mask and a single level on a one-cycle start pulse. The sequencer then writes that level into every masked channel, and into no other. It can update one channel or a whole group.

For a group, the level stays fixed and select stays low while the address steps through positions in reflected-binary order, where channel = pos ^ (pos >> 1). Only one address bit changes per step, so no stray channel is ever decoded on the way. When the masked channels in that order are not contiguous, select is raised at the end of each run. The address is then moved with select high, and select is lowered again for the next run. Setup, hold and pulse-width limits are programmed as clock counts.

The command side is plain control: `start` is accepted only while `busy` is low, and `done` marks completion. No back-pressure applies. The caller must wait for `busy` to fall, and a start seen while busy is dropped.

Top module: `gray_group_seq`

## Requirements
- R1: While reset is asserted and right after it, `sel_n` is 1 and `busy` and `done` are 0.
- R2: Masked channels are written in reflected-binary position order, channel = pos ^ (pos >> 1). For eight channels that order is 0, 1, 3, 2, 6, 7, 5, 4.
- R3: While `sel_n` stays low, each address change flips exactly one address bit.
- R4: A channel whose mask bit is 0 is never on `sel_addr` while `sel_n` is low.
- R5: Masked channels that are adjacent in position order are written in one low pulse of `sel_n`. `sel_data` equals the requested level and does not change while `busy` is high.
- R6: Between two runs, `sel_n` is high for exactly HOLD_CYC+1 cycles. The address moves only while `sel_n` is high.
- R7: Each address stays on `sel_addr` with `sel_n` low for exactly DWELL = max(SETUP_CYC, PULSE_CYC) cycles. This meets both the setup limit and the pulse-width limit.
- R8: After `sel_n` rises, `sel_addr` holds for at least HOLD_CYC cycles.
- R9: `busy` rises in the cycle after start is accepted. `done` is high for one cycle, in the same cycle that `busy` falls. For m runs covering k channels, that happens m*(1+HOLD_CYC)+k*DWELL cycles after the start edge.
- R10: A start while `busy` is high is ignored, and the running update continues unchanged.
- R11: A start with an all-zero mask causes no select activity. `done` follows HOLD_CYC cycles after the start edge.
- R12: A single-bit mask gives one select pulse of DWELL cycles at that channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request, taken only while idle |
| chan_mask | input | N_CH | Channels to write |
| level | input | 1 | Level to write (1 on, 0 off) |
| busy | output | 1 | Update in progress |
| done | output | 1 | One-cycle completion pulse |
| sel_addr | output | AW | Channel address to the latch bank |
| sel_data | output | 1 | Data line to the latch bank |
| sel_n | output | 1 | Active-low select to the latch bank |

## Verification
The bound checker checks several rules on every cycle: single-bit address steps under select and the mask guard on the decoded address. It also checks the pulse-width, setup and hold windows, which it measures with its own counters, and that the data line stays stable and `done` behaves as a pulse. The order of the walk, the split into runs, the exact gap and completion cycle counts, the ignored start during a busy update, and the silent zero-mask case depend on the command given. Only the bench scenarios can show these, by comparing every select event against a queue of expected writes.

// File: rtl/gray_group_seq_pkg.sv
package gray_group_seq_pkg;
  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_ARM  = 2'd1,
    SQ_LOW  = 2'd2,
    SQ_HOLD = 2'd3
  } seq_state_t;
endpackage

// File: rtl/seq_wait_timer.sv
module seq_wait_timer #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] len,
  output logic          expired
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (load)       cnt <= len;
    else if (cnt != '0)  cnt <= cnt - CW'(1);
  end

  assign expired = (cnt == '0);
endmodule

// File: rtl/gray_mask_scan.sv
// Finds the lowest walk position above after_pos (or the lowest overall
// when from_start is set) whose reflected-binary channel is in the mask.
module gray_mask_scan #(
  parameter int N_CH = 8,
  parameter int AW   = 3
) (
  input  logic [N_CH-1:0] mask,
  input  logic [AW-1:0]   after_pos,
  input  logic            from_start,
  output logic            found,
  output logic [AW-1:0]   nxt_pos,
  output logic [AW-1:0]   nxt_chan
);
  always_comb begin
    found   = 1'b0;
    nxt_pos = '0;
    for (int q = N_CH - 1; q >= 0; q--) begin
      if (mask[AW'(q) ^ (AW'(q) >> 1)] && (from_start || (AW'(q) > after_pos))) begin
        found   = 1'b1;
        nxt_pos = AW'(q);
      end
    end
    nxt_chan = nxt_pos ^ (nxt_pos >> 1);
  end
endmodule

// File: rtl/gray_group_seq.sv
module gray_group_seq
  import gray_group_seq_pkg::*;
#(
  parameter int N_CH      = 8,
  parameter int SETUP_CYC = 40,
  parameter int HOLD_CYC  = 5,
  parameter int PULSE_CYC = 50
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start,
  input  logic [N_CH-1:0]          chan_mask,
  input  logic                     level,
  output logic                     busy,
  output logic                     done,
  output logic [$clog2(N_CH)-1:0]  sel_addr,
  output logic                     sel_data,
  output logic                     sel_n
);
  localparam int AW    = $clog2(N_CH);
  localparam int DWELL = (SETUP_CYC > PULSE_CYC) ? SETUP_CYC : PULSE_CYC;
  localparam int TMAX  = (DWELL > HOLD_CYC) ? DWELL : HOLD_CYC;
  localparam int CW    = $clog2(TMAX + 1);
  localparam logic [CW-1:0] DWELL_LEN = CW'(DWELL - 1);
  localparam logic [CW-1:0] HOLD_LEN  = CW'(HOLD_CYC - 1);

  seq_state_t      state;
  logic [AW-1:0]   pos;
  logic [AW-1:0]   addr_q;
  logic            data_q;
  logic            sel_n_q;
  logic            done_q;
  logic [N_CH-1:0] mask_q;

  logic            first_found, nx_found, contig;
  logic [AW-1:0]   first_pos, first_chan, nx_pos, nx_chan;
  logic            t_load, t_zero;
  logic [CW-1:0]   t_len;

  gray_mask_scan #(.N_CH(N_CH), .AW(AW)) u_scan_first (
    .mask(chan_mask), .after_pos(pos), .from_start(1'b1),
    .found(first_found), .nxt_pos(first_pos), .nxt_chan(first_chan)
  );

  gray_mask_scan #(.N_CH(N_CH), .AW(AW)) u_scan_next (
    .mask(mask_q), .after_pos(pos), .from_start(1'b0),
    .found(nx_found), .nxt_pos(nx_pos), .nxt_chan(nx_chan)
  );

  seq_wait_timer #(.CW(CW)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(t_load), .len(t_len), .expired(t_zero)
  );

  assign contig = nx_found && (nx_pos == pos + AW'(1));

  always_comb begin
    t_load = 1'b0;
    t_len  = '0;
    unique case (state)
      SQ_IDLE: if (start && !first_found) begin t_load = 1'b1; t_len = HOLD_LEN; end
      SQ_ARM:  begin t_load = 1'b1; t_len = DWELL_LEN; end
      SQ_LOW:  if (t_zero) begin t_load = 1'b1; t_len = contig ? DWELL_LEN : HOLD_LEN; end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= SQ_IDLE;
      pos     <= '0;
      addr_q  <= '0;
      data_q  <= 1'b0;
      sel_n_q <= 1'b1;
      done_q  <= 1'b0;
      mask_q  <= '0;
    end else begin
      done_q <= 1'b0;
      unique case (state)
        SQ_IDLE: if (start) begin
          mask_q <= chan_mask;
          data_q <= level;
          if (first_found) begin
            pos    <= first_pos;
            addr_q <= first_chan;
            state  <= SQ_ARM;
          end else begin
            pos   <= '0;
            state <= SQ_HOLD;
          end
        end
        SQ_ARM: begin
          sel_n_q <= 1'b0;
          state   <= SQ_LOW;
        end
        SQ_LOW: if (t_zero) begin
          if (contig) begin
            pos    <= nx_pos;
            addr_q <= nx_chan;
          end else begin
            sel_n_q <= 1'b1;
            state   <= SQ_HOLD;
          end
        end
        SQ_HOLD: if (t_zero) begin
          if (nx_found) begin
            pos    <= nx_pos;
            addr_q <= nx_chan;
            state  <= SQ_ARM;
          end else begin
            state  <= SQ_IDLE;
            done_q <= 1'b1;
          end
        end
        default: state <= SQ_IDLE;
      endcase
    end
  end

  assign busy     = (state != SQ_IDLE);
  assign done     = done_q;
  assign sel_addr = addr_q;
  assign sel_data = data_q;
  assign sel_n    = sel_n_q;
endmodule

// File: rtl/gray_group_seq_chk.sv
module gray_group_seq_chk #(
  parameter int N_CH      = 8,
  parameter int AW        = 3,
  parameter int SETUP_CYC = 40,
  parameter int HOLD_CYC  = 5,
  parameter int PULSE_CYC = 50
) (
  input logic            clk,
  input logic            rst_n,
  input logic            sel_n,
  input logic [AW-1:0]   sel_addr,
  input logic            sel_data,
  input logic            busy,
  input logic            done,
  input logic [N_CH-1:0] mask_q
);
  logic [15:0]   low_run, high_run, addr_age;
  logic [AW-1:0] prev_addr;

  function automatic logic [15:0] sat_inc(input logic [15:0] v);
    return (v == 16'hFFFF) ? v : v + 16'd1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_run   <= '0;
      high_run  <= '1;
      addr_age  <= '1;
      prev_addr <= '0;
    end else begin
      low_run   <= sel_n ? 16'd0 : sat_inc(low_run);
      high_run  <= sel_n ? sat_inc(high_run) : 16'd0;
      addr_age  <= (sel_addr != prev_addr) ? 16'd1 : sat_inc(addr_age);
      prev_addr <= sel_addr;
    end
  end

  assert_one_bit_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_n && !$past(sel_n) && sel_addr != $past(sel_addr))
      |-> $countones(sel_addr ^ $past(sel_addr)) == 1);

  assert_masked_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_n |-> mask_q[sel_addr]);

  assert_data_steady_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(sel_data));

  assert_pulse_width_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sel_n) |-> low_run >= 16'(PULSE_CYC));

  assert_setup_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sel_n) |-> addr_age >= 16'(SETUP_CYC));

  assert_addr_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_n && $past(sel_n) && sel_addr != $past(sel_addr)) |-> high_run >= 16'(HOLD_CYC));

  assert_done_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

bind gray_group_seq gray_group_seq_chk #(
  .N_CH(N_CH), .AW(AW), .SETUP_CYC(SETUP_CYC), .HOLD_CYC(HOLD_CYC), .PULSE_CYC(PULSE_CYC)
) u_chk (
  .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .sel_addr(sel_addr), .sel_data(sel_data),
  .busy(busy), .done(done), .mask_q(mask_q)
);

// File: tb/tb_gray_group_seq.sv
module tb_gray_group_seq;
  localparam int CLK_PERIOD = 10;
  localparam int N_CH  = 8;
  localparam int AW    = 3;
  localparam int SETUP = 3;
  localparam int HOLD  = 2;
  localparam int PULSE = 4;
  localparam int DWELL = (SETUP > PULSE) ? SETUP : PULSE;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [N_CH-1:0] chan_mask = '0;
  logic level = 1'b0;
  logic busy, done, sel_data, sel_n;
  logic [AW-1:0] sel_addr;

  int checks = 0;
  int errors = 0;
  bit first_of_op = 1'b0;
  bit finished = 1'b0;
  logic [AW+1:0] exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  gray_group_seq #(.N_CH(N_CH), .SETUP_CYC(SETUP), .HOLD_CYC(HOLD), .PULSE_CYC(PULSE)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .chan_mask(chan_mask), .level(level),
    .busy(busy), .done(done), .sel_addr(sel_addr), .sel_data(sel_data), .sel_n(sel_n)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Monitor: compares select events against the expected queue.
  task automatic pop_cmp(input logic fresh);
    logic [AW+1:0] e;
    if (exp_q.size() == 0) begin
      check(1'b0, "R4/R11 unexpected select", int'(sel_addr), -1);
    end else begin
      e = exp_q.pop_front();
      check(sel_addr == e[AW-1:0], "R2/R4 channel order", int'(sel_addr), int'(e[AW-1:0]));
      check(sel_data == e[AW], "R5 data level", int'(sel_data), int'(e[AW]));
      check(fresh == e[AW+1], "R5/R6 run split", int'(fresh), int'(e[AW+1]));
    end
  endtask

  logic prv_n = 1'b1;
  logic [AW-1:0] prv_addr = '0;
  int dwell = 0;
  int hi = 1000;

  always @(negedge clk) begin
    if (rst_n) begin
      if (!sel_n) begin
        if (prv_n) begin
          if (!first_of_op) check(hi == HOLD + 1, "R6 gap length", hi, HOLD + 1);
          first_of_op = 1'b0;
          pop_cmp(1'b1);
          dwell = 1;
        end else if (sel_addr != prv_addr) begin
          check(dwell == DWELL, "R7 dwell", dwell, DWELL);
          pop_cmp(1'b0);
          dwell = 1;
        end else begin
          dwell++;
        end
        hi = 0;
      end else begin
        if (!prv_n) begin
          check(dwell == DWELL, "R7 last dwell", dwell, DWELL);
          hi = 1;
        end else begin
          if (sel_addr != prv_addr)
            check(hi >= HOLD, "R8 address hold", hi, HOLD);
          if (hi < 1000) hi++;
        end
      end
      prv_n = sel_n;
      prv_addr = sel_addr;
    end
  end

  // Driver: pushes expected writes, issues the command, times completion.
  task automatic run_op(input logic [N_CH-1:0] m, input logic lvl, input bit poke);
    bit prev_in;
    int runs, k, t_exp, cnt;
    prev_in = 1'b0; runs = 0; k = 0;
    for (int p = 0; p < N_CH; p++) begin
      logic [AW-1:0] g;
      g = AW'(p) ^ (AW'(p) >> 1);
      if (m[g]) begin
        exp_q.push_back({~prev_in, lvl, g});
        if (!prev_in) runs++;
        k++;
      end
      prev_in = m[g];
    end
    t_exp = (k == 0) ? HOLD : runs * (1 + HOLD) + k * DWELL;
    @(negedge clk);
    first_of_op = 1'b1;
    start = 1'b1; chan_mask = m; level = lvl;
    @(negedge clk);
    start = 1'b0;
    check(busy == 1'b1, "R9 busy rises", int'(busy), 1);
    cnt = 1;
    while (!done && cnt < t_exp + 4) begin
      if (poke && cnt == 3) begin
        start = 1'b1; chan_mask = ~m; level = ~lvl;
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
      cnt++;
    end
    start = 1'b0;
    check(done && cnt == t_exp + 1, "R9 done timing", cnt, t_exp + 1);
    check(busy == 1'b0, "R9 busy falls with done", int'(busy), 0);
    @(negedge clk);
    check(done == 1'b0, "R9 done one cycle", int'(done), 0);
    check(exp_q.size() == 0, poke ? "R10 busy start ignored" : "R2 all writes seen",
          exp_q.size(), 0);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(sel_n == 1'b1 && busy == 1'b0 && done == 1'b0, "R1 reset outputs",
          int'({sel_n, busy, done}), 4);
    rst_n = 1'b1;
    @(negedge clk);
    check(sel_n == 1'b1 && busy == 1'b0, "R1 after reset", int'({sel_n, busy}), 2);
    run_op(8'h20, 1'b1, 1'b0);   // R12 single channel 5
    run_op(8'hFF, 1'b1, 1'b0);   // R2 R3 R5 full walk, one pulse
    run_op(8'hC3, 1'b0, 1'b0);   // R6 channels 0,1,6,7: two runs, turn off
    run_op(8'h91, 1'b1, 1'b0);   // R6 channels 0,4,7: three separate pulses
    run_op(8'h00, 1'b1, 1'b0);   // R11 empty mask
    run_op(8'h0F, 1'b1, 1'b1);   // R10 start during busy
    run_op(8'h40, 1'b0, 1'b0);   // R12 single channel off
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule